// File: doc/BRIEF.md
# Serial Command Frame Front End

This block is the slave side of a four-wire serial link that carries fixed 16-bit command words from a host to the register file of a UART. All of its logic runs on one system clock. Chip select, serial clock and data in are brought across through synchronizer chains, and the block acts on the edges it detects in those synchronized copies. Input bits are taken on rising serial-clock edges. The reply word is moved onto data out on falling edges.

The first two bits of each word give the operation. The other fourteen bits form the payload. No register-side effect happens while the frame is still being shifted in. Each effect is released as a single-cycle strobe after chip select goes high, and only when exactly sixteen rising edges were seen. The exception is the interrupt-mask field of a configuration write: it is announced as soon as the sixteenth bit arrives. The reply word comes from a parallel input and is captured when chip select falls.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A frame runs from a falling edge of chip select to the next rising edge. It is committed only if exactly 16 rising serial-clock edges occurred in between. A commit gives one `cmd_stb` pulse after chip select rises.
- R2: Data in is sampled on rising serial-clock edges, most significant bit first. `cmd_payload` holds word bits 13..0, and `cmd_op` holds word bits 15..14.
- R3: `rd_word` is captured when chip select falls and is shifted out most significant bit first. Data out moves to the next bit only after a falling serial-clock edge, so it is stable at every rising edge.
- R4: When chip select rises after fewer than 16 rising edges, including zero, no strobe of any kind is produced.
- R5: Opcode 11 raises `cfg_wr_stb`, 01 raises `cfg_rd_stb`, 10 raises `rts_stb` and 00 raises `rx_ack_stb`. Each pulses together with `cmd_stb` and never before chip select rises.
- R6: For opcode 11, `mask_stb` pulses after the 16th rising edge while chip select is still low. `mask_val` then equals word bits 13..10. No other opcode raises `mask_stb`.
- R7: A committed data write (opcode 10) sets `rts_level` to word bit 9. It also raises `tx_load_stb`, but only when word bit 10, the load-inhibit bit, is 0.
- R8: A committed data read (opcode 00) gives a single `rx_ack_stb` pulse, which the register side uses to clear its receive-ready flag and interrupt.
- R9: Serial-clock edges while chip select is high are ignored and leave the bit count at zero for the next frame.
- R10: A frame with more than 16 rising edges is discarded at chip-select release.
- R11: After reset, all strobes, `spi_miso`, `cmd_op`, `cmd_payload`, `rts_level` and `mask_val` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| rd_word | input | 16 | Reply word, captured at chip-select fall |
| cmd_stb | output | 1 | Frame commit pulse |
| cmd_op | output | 2 | Opcode of last committed frame |
| cmd_payload | output | 14 | Payload of last committed frame |
| cfg_wr_stb | output | 1 | Configuration write pulse |
| cfg_rd_stb | output | 1 | Configuration read pulse |
| tx_load_stb | output | 1 | Transmit buffer load pulse |
| rts_stb | output | 1 | Handshake output update pulse |
| rts_level | output | 1 | Handshake level from last data write |
| rx_ack_stb | output | 1 | Data read pulse |
| mask_stb | output | 1 | Early interrupt-mask update pulse |
| mask_val | output | 4 | Interrupt-mask field |

## Verification
The assertions assume the serial inputs change slowly compared with the system clock. Every serial-clock half period, and every interval between a chip-select edge and a serial-clock edge, is assumed to last longer than the synchronizer depth plus one cycle. Under that assumption, data out has settled before each rising edge, and each commit strobe falls inside the high phase of chip select. The stimulus holds every phase for six system clocks and keeps chip select high for eighteen. Random words, reply values, frame lengths and idle clock bursts are applied only on that fixed grid.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
   typedef enum logic [1:0] {
      OP_RD_DATA = 2'b00,
      OP_RD_CFG  = 2'b01,
      OP_WR_DATA = 2'b10,
      OP_WR_CFG  = 2'b11
   } spi_op_e;

   localparam int OP_W = 2;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift #(
   parameter int FRAME_BITS = 16,
   parameter bit MSB_FIRST  = 1'b1,
   localparam int CW        = $clog2(FRAME_BITS + 2)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_act,
   input  logic                  cs_fall_ev,
   input  logic                  sclk_rise_ev,
   input  logic                  sclk_fall_ev,
   input  logic                  mosi_s,
   input  logic [FRAME_BITS-1:0] rd_word,
   output logic [FRAME_BITS-1:0] rx_word,
   output logic                  frame_full,
   output logic                  miso_bit
);
   if (FRAME_BITS < 4) begin : g_bad_frame
      $error("spi_frame_shift: FRAME_BITS too small");
   end

   localparam logic [CW-1:0] FULL_CNT = CW'(FRAME_BITS);
   localparam logic [CW-1:0] OVER_CNT = CW'(FRAME_BITS + 1);

   logic [CW-1:0]         cnt;
   logic [FRAME_BITS-1:0] tx_sh;
   logic                  take_bit;

   assign take_bit   = cs_act && sclk_rise_ev && (cnt < FULL_CNT);
   assign frame_full = (cnt == FULL_CNT);

   // bit counter saturates one past full so long frames are recognisable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt <= '0;
      else if (!cs_act)                        cnt <= '0;
      else if (sclk_rise_ev && cnt != OVER_CNT) cnt <= cnt + 1'b1;
   end

   if (MSB_FIRST) begin : g_msb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rx_word <= '0;
         else if (!cs_act)  rx_word <= '0;
         else if (take_bit) rx_word <= {rx_word[FRAME_BITS-2:0], mosi_s};
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      tx_sh <= '0;
         else if (!cs_act)                tx_sh <= '0;
         else if (cs_fall_ev)             tx_sh <= rd_word;
         else if (sclk_fall_ev)           tx_sh <= {tx_sh[FRAME_BITS-2:0], 1'b0};
      end
      assign miso_bit = tx_sh[FRAME_BITS-1];
   end else begin : g_lsb
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        rx_word <= '0;
         else if (!cs_act)  rx_word <= '0;
         else if (take_bit) rx_word <= {mosi_s, rx_word[FRAME_BITS-1:1]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      tx_sh <= '0;
         else if (!cs_act)                tx_sh <= '0;
         else if (cs_fall_ev)             tx_sh <= rd_word;
         else if (sclk_fall_ev)           tx_sh <= {1'b0, tx_sh[FRAME_BITS-1:1]};
      end
      assign miso_bit = tx_sh[0];
   end
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_cmd_pkg::*;
#(
   parameter int FRAME_BITS = 16,
   parameter int MASK_W     = 4,
   parameter int MASK_LSB   = 10,
   parameter int TE_BIT     = 10,
   parameter int RTS_BIT    = 9,
   localparam int PW        = FRAME_BITS - OP_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cs_rise_ev,
   input  logic                  frame_full,
   input  logic [FRAME_BITS-1:0] rx_word,
   output logic                  cmd_stb,
   output logic [OP_W-1:0]       cmd_op,
   output logic [PW-1:0]         cmd_payload,
   output logic                  cfg_wr_stb,
   output logic                  cfg_rd_stb,
   output logic                  tx_load_stb,
   output logic                  rts_stb,
   output logic                  rts_level,
   output logic                  rx_ack_stb,
   output logic                  mask_stb,
   output logic [MASK_W-1:0]     mask_val
);
   if (MASK_LSB + MASK_W > PW) begin : g_bad_mask
      $error("spi_cmd_decode: mask field outside payload");
   end
   if (TE_BIT >= PW || RTS_BIT >= PW || TE_BIT == RTS_BIT) begin : g_bad_data
      $error("spi_cmd_decode: data-write control bits misplaced");
   end

   localparam int N_OPS = 1 << OP_W;

   logic            commit;
   logic            full_q;
   logic [OP_W-1:0] op_field;
   logic [N_OPS-1:0] op_hit;

   assign op_field = rx_word[FRAME_BITS-1 -: OP_W];
   assign commit   = cs_rise_ev && frame_full;

   for (genvar k = 0; k < N_OPS; k++) begin : g_op
      assign op_hit[k] = commit && (op_field == OP_W'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_stb     <= 1'b0;
         cmd_op      <= '0;
         cmd_payload <= '0;
         cfg_wr_stb  <= 1'b0;
         cfg_rd_stb  <= 1'b0;
         tx_load_stb <= 1'b0;
         rts_stb     <= 1'b0;
         rts_level   <= 1'b0;
         rx_ack_stb  <= 1'b0;
      end else begin
         cmd_stb     <= commit;
         cfg_wr_stb  <= op_hit[OP_WR_CFG];
         cfg_rd_stb  <= op_hit[OP_RD_CFG];
         rts_stb     <= op_hit[OP_WR_DATA];
         tx_load_stb <= op_hit[OP_WR_DATA] && !rx_word[TE_BIT];
         rx_ack_stb  <= op_hit[OP_RD_DATA];
         if (commit) begin
            cmd_op      <= op_field;
            cmd_payload <= rx_word[PW-1:0];
         end
         if (op_hit[OP_WR_DATA]) rts_level <= rx_word[RTS_BIT];
      end
   end

   // mask field is released on the arrival of the last bit, not on release
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q   <= 1'b0;
         mask_stb <= 1'b0;
         mask_val <= '0;
      end else begin
         full_q   <= frame_full;
         mask_stb <= frame_full && !full_q && (op_field == OP_WR_CFG);
         if (frame_full && !full_q && (op_field == OP_WR_CFG))
            mask_val <= rx_word[MASK_LSB +: MASK_W];
      end
   end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend #(
   parameter int FRAME_BITS  = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit MSB_FIRST   = 1'b1,
   parameter int MASK_W      = 4,
   parameter int MASK_LSB    = 10,
   parameter int TE_BIT      = 10,
   parameter int RTS_BIT     = 9,
   localparam int PW         = FRAME_BITS - 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spi_cs_n,
   input  logic                  spi_sclk,
   input  logic                  spi_mosi,
   output logic                  spi_miso,
   input  logic [FRAME_BITS-1:0] rd_word,
   output logic                  cmd_stb,
   output logic [1:0]            cmd_op,
   output logic [PW-1:0]         cmd_payload,
   output logic                  cfg_wr_stb,
   output logic                  cfg_rd_stb,
   output logic                  tx_load_stb,
   output logic                  rts_stb,
   output logic                  rts_level,
   output logic                  rx_ack_stb,
   output logic                  mask_stb,
   output logic [MASK_W-1:0]     mask_val
);
   // synchronized vector: [2] chip select, [1] serial clock, [0] data in
   logic [2:0] pins_s;
   logic       cs_q, sclk_q;
   logic       cs_act, cs_fall_ev, cs_rise_ev, sclk_rise_ev, sclk_fall_ev;
   logic [FRAME_BITS-1:0] rx_word;
   logic       frame_full;

   spi_in_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({spi_cs_n, spi_sclk, spi_mosi}),
      .dout  (pins_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q   <= 1'b1;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= pins_s[2];
         sclk_q <= pins_s[1];
      end
   end

   assign cs_act       = !pins_s[2];
   assign cs_fall_ev   = !pins_s[2] && cs_q;
   assign cs_rise_ev   = pins_s[2] && !cs_q;
   assign sclk_rise_ev = pins_s[1] && !sclk_q;
   assign sclk_fall_ev = !pins_s[1] && sclk_q;

   spi_frame_shift #(
      .FRAME_BITS (FRAME_BITS),
      .MSB_FIRST  (MSB_FIRST)
   ) u_shift (
      .clk          (clk),
      .rst_n        (rst_n),
      .cs_act       (cs_act),
      .cs_fall_ev   (cs_fall_ev),
      .sclk_rise_ev (sclk_rise_ev),
      .sclk_fall_ev (sclk_fall_ev),
      .mosi_s       (pins_s[0]),
      .rd_word      (rd_word),
      .rx_word      (rx_word),
      .frame_full   (frame_full),
      .miso_bit     (spi_miso)
   );

   spi_cmd_decode #(
      .FRAME_BITS (FRAME_BITS),
      .MASK_W     (MASK_W),
      .MASK_LSB   (MASK_LSB),
      .TE_BIT     (TE_BIT),
      .RTS_BIT    (RTS_BIT)
   ) u_dec (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_rise_ev  (cs_rise_ev),
      .frame_full  (frame_full),
      .rx_word     (rx_word),
      .cmd_stb     (cmd_stb),
      .cmd_op      (cmd_op),
      .cmd_payload (cmd_payload),
      .cfg_wr_stb  (cfg_wr_stb),
      .cfg_rd_stb  (cfg_rd_stb),
      .tx_load_stb (tx_load_stb),
      .rts_stb     (rts_stb),
      .rts_level   (rts_level),
      .rx_ack_stb  (rx_ack_stb),
      .mask_stb    (mask_stb),
      .mask_val    (mask_val)
   );
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       spi_cs_n,
   input logic       spi_sclk,
   input logic       spi_miso,
   input logic       cmd_stb,
   input logic [1:0] cmd_op,
   input logic       cfg_wr_stb,
   input logic       cfg_rd_stb,
   input logic       tx_load_stb,
   input logic       rts_stb,
   input logic       rx_ack_stb,
   input logic       mask_stb
);
   // R1: a commit is a single-cycle pulse
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> !cmd_stb);

   // R3: data out does not move across a rising serial-clock edge
   a_r3_miso_settled: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && $rose(spi_sclk)) |-> $stable(spi_miso));

   // R4: commits only appear once chip select is released
   a_r4_commit_released: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |-> spi_cs_n);

   // R5: operation strobes ride on the commit pulse
   a_r5_op_with_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_stb || cfg_rd_stb || rts_stb || rx_ack_stb || tx_load_stb) |-> cmd_stb);

   // R5: at most one operation per commit
   a_r5_one_op: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_wr_stb, cfg_rd_stb, rts_stb, rx_ack_stb}));

   // R6: mask update precedes release
   a_r6_mask_selected: assert property (@(posedge clk) disable iff (!rst_n)
      mask_stb |-> !spi_cs_n);

   // R7: a buffer load is always part of a data write
   a_r7_load_is_write: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load_stb |-> (rts_stb && cmd_op == 2'b10));

   // R8: acknowledge only for a data read
   a_r8_ack_read: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack_stb |-> (cmd_op == 2'b00));
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .spi_cs_n    (spi_cs_n),
   .spi_sclk    (spi_sclk),
   .spi_miso    (spi_miso),
   .cmd_stb     (cmd_stb),
   .cmd_op      (cmd_op),
   .cfg_wr_stb  (cfg_wr_stb),
   .cfg_rd_stb  (cfg_rd_stb),
   .tx_load_stb (tx_load_stb),
   .rts_stb     (rts_stb),
   .rx_ack_stb  (rx_ack_stb),
   .mask_stb    (mask_stb)
);

// File: tb/sim_spi_cmd_frontend.sv
`timescale 1ns/1ps
module sim_spi_cmd_frontend;
   localparam int HP = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_sclk = 1'b0;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic [15:0] rd_word = '0;
   logic        cmd_stb, cfg_wr_stb, cfg_rd_stb, tx_load_stb, rts_stb;
   logic        rts_level, rx_ack_stb, mask_stb;
   logic [1:0]  cmd_op;
   logic [13:0] cmd_payload;
   logic [3:0]  mask_val;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int n_cmd = 0, n_cfgw = 0, n_cfgr = 0, n_tx = 0, n_rts = 0, n_ack = 0, n_mask = 0;

   always #4 clk = ~clk;

   spi_cmd_frontend u0 (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .rd_word(rd_word),
      .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_payload(cmd_payload),
      .cfg_wr_stb(cfg_wr_stb), .cfg_rd_stb(cfg_rd_stb), .tx_load_stb(tx_load_stb),
      .rts_stb(rts_stb), .rts_level(rts_level), .rx_ack_stb(rx_ack_stb),
      .mask_stb(mask_stb), .mask_val(mask_val)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (cmd_stb)     n_cmd  <= n_cmd + 1;
         if (cfg_wr_stb)  n_cfgw <= n_cfgw + 1;
         if (cfg_rd_stb)  n_cfgr <= n_cfgr + 1;
         if (tx_load_stb) n_tx   <= n_tx + 1;
         if (rts_stb)     n_rts  <= n_rts + 1;
         if (rx_ack_stb)  n_ack  <= n_ack + 1;
         if (mask_stb)    n_mask <= n_mask + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n * HP) @(negedge clk);
   endtask

   function automatic int f_is(input logic [15:0] w, input logic [1:0] op, input bit valid);
      return (valid && w[15:14] == op) ? 1 : 0;
   endfunction

   function automatic int f_load(input logic [15:0] w, input bit valid);
      return (valid && w[15:14] == 2'b10 && !w[10]) ? 1 : 0;
   endfunction

   task automatic frame(input logic [15:0] w, input int nbits, input logic [15:0] rdw);
      int s_cmd = n_cmd, s_cfgw = n_cfgw, s_cfgr = n_cfgr, s_tx = n_tx;
      int s_rts = n_rts, s_ack = n_ack, s_mask = n_mask;
      bit valid = (nbits == 16);
      bit mask_exp = (nbits >= 16) && (w[15:14] == 2'b11);
      bit miso_bad = 1'b0;
      logic [31:0] bad_got = '0, bad_exp = '0;
      logic rts_before = rts_level;
      @(negedge clk);
      rd_word  = rdw;
      spi_cs_n = 1'b0;
      wt(1);
      rd_word = 16'($urandom);   // must not matter after capture
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 16) ? w[15-i] : 1'($urandom);
         wt(1);
         if (i < 16 && spi_miso !== rdw[15-i] && !miso_bad) begin
            miso_bad = 1'b1;
            bad_got  = {31'b0, spi_miso};
            bad_exp  = {31'b0, rdw[15-i]};
         end
         spi_sclk = 1'b1;
         wt(1);
         spi_sclk = 1'b0;
      end
      wt(1);
      if (nbits > 0) chk(!miso_bad, "R3 data out bit", bad_got, bad_exp);
      chk(n_cmd == s_cmd, "R5 no commit before release", n_cmd - s_cmd, 0);
      chk((n_mask - s_mask) == int'(mask_exp), "R6 early mask pulse", n_mask - s_mask, int'(mask_exp));
      if (mask_exp) chk(mask_val == w[13:10], "R6 mask field", mask_val, w[13:10]);
      spi_cs_n = 1'b1;
      wt(3);
      spi_mosi = 1'b0;
      chk((n_cmd - s_cmd) == int'(valid), nbits < 16 ? "R4 short frame commit" :
          (nbits > 16 ? "R10 long frame commit" : "R1 commit count"), n_cmd - s_cmd, int'(valid));
      chk((n_cfgw - s_cfgw) == f_is(w, 2'b11, valid), "R5 config write strobe", n_cfgw - s_cfgw, f_is(w, 2'b11, valid));
      chk((n_cfgr - s_cfgr) == f_is(w, 2'b01, valid), "R5 config read strobe", n_cfgr - s_cfgr, f_is(w, 2'b01, valid));
      chk((n_rts - s_rts) == f_is(w, 2'b10, valid), "R7 rts strobe", n_rts - s_rts, f_is(w, 2'b10, valid));
      chk((n_tx - s_tx) == f_load(w, valid), "R7 load strobe", n_tx - s_tx, f_load(w, valid));
      chk((n_ack - s_ack) == f_is(w, 2'b00, valid), "R8 read ack strobe", n_ack - s_ack, f_is(w, 2'b00, valid));
      if (valid) begin
         chk(cmd_op == w[15:14], "R2 opcode", cmd_op, w[15:14]);
         chk(cmd_payload == w[13:0], "R2 payload", cmd_payload, w[13:0]);
         if (w[15:14] == 2'b10) chk(rts_level == w[9], "R7 rts level", rts_level, w[9]);
      end
      if (!(valid && w[15:14] == 2'b10))
         chk(rts_level == rts_before, "R7 rts level kept", rts_level, rts_before);
   endtask

   task automatic idle_clocks(input int k);
      int s_cmd = n_cmd, s_mask = n_mask;
      for (int i = 0; i < k; i++) begin
         spi_mosi = 1'($urandom);
         spi_sclk = 1'b1;
         wt(1);
         spi_sclk = 1'b0;
         wt(1);
      end
      chk(n_cmd == s_cmd && n_mask == s_mask, "R9 clocks while deselected", n_cmd - s_cmd, 0);
   endtask

   initial begin
      void'($urandom(32'h5A17_0C3D));
      repeat (5) @(negedge clk);
      chk(!cmd_stb && !mask_stb && !tx_load_stb && !rts_stb && !rx_ack_stb && !cfg_wr_stb && !cfg_rd_stb,
          "R11 strobes in reset", 0, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(spi_miso == 1'b0, "R11 data out after reset", spi_miso, 0);
      chk({cmd_op, cmd_payload, rts_level, mask_val} == '0, "R11 held outputs after reset",
          {cmd_op, cmd_payload, rts_level, mask_val}, 0);

      // directed: each opcode, load inhibit, bounds
      frame(16'hF6A5, 16, 16'hA55A);   // config write, mask 1101
      frame(16'h4321, 16, 16'h8001);   // config read
      frame(16'h8200, 16, 16'hFFFF);   // data write, rts 1, load
      frame(16'h8455, 16, 16'h0000);   // data write, inhibit set
      frame(16'h8000, 16, 16'h1234);   // data write, rts 0, load
      frame(16'h0000, 16, 16'hC3C3);   // data read
      frame(16'hFFFF, 15, 16'h7E7E);   // short by one
      frame(16'h8000, 0, 16'h0F0F);    // empty select
      frame(16'hC3FF, 17, 16'hBEEF);   // long by one, mask still early
      idle_clocks(5);
      frame(16'h3FFF, 16, 16'h0001);   // counter starts clean after idle clocks

      for (int n = 0; n < 120; n++) begin
         logic [15:0] w = 16'($urandom);
         logic [15:0] r = 16'($urandom);
         int sel = int'($urandom % 10);
         int nb = (sel < 7) ? 16 : (sel == 7 ? int'($urandom % 16) : 17 + int'($urandom % 3));
         if ($urandom % 4 == 0) idle_clocks(1 + int'($urandom % 4));
         frame(w, nb, r);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule